// File: doc/BRIEF.md
# UART Receive Interrupt Generator

This block decides when the receive side of a 16550-style UART should interrupt the host. It never touches the serial line or the character storage. It watches the occupancy of the receive FIFO and the error flags of the oldest stored entry, and it observes strobes from the receiver and from the host. From these it derives three pending conditions: a line-status error, data available and character timeout. It gates each condition with its own enable bit, merges the enabled ones onto a single interrupt line, and encodes the most urgent one as a four-bit identification code.

FIFO mode and single-buffer (non-FIFO) mode are selected by one input. In single-buffer mode the occupancy count is 0 or 1. Time is measured in character times by a one-cycle tick that the baud logic supplies. The character timeout therefore needs no knowledge of the baud rate or the frame length. For example, at 1200 baud with 12-bit frames one character time is 10 ms.

Two state machines hold the registered behaviour.

The line-status machine has three states:
- `LS_IDLE` moves to `LS_PEND` when a stored character shows an error and no status read occurs in the same cycle.
- `LS_PEND` moves to `LS_HELD` on a status read.
- `LS_HELD` returns to `LS_IDLE` when the host reads a data character.
- A flush (FIFO reset or mode change) returns the machine to `LS_IDLE` from either `LS_PEND` or `LS_HELD`.

The timeout machine also has three states:
- `TO_OFF` moves to `TO_RUN` whenever FIFO mode is active and the FIFO holds data.
- `TO_RUN` moves to `TO_FIRED` when the tick counter saturates.
- `TO_FIRED` returns to `TO_RUN` on a host data read.
- Any state falls back to `TO_OFF` on a FIFO reset, a mode change, non-FIFO mode or an empty FIFO.

Top module: `uart_rx_irq`

## Requirements
- R1: After reset all three interrupt outputs and `irq` are 0 and `irq_id` reads 4'b0001 (nothing pending).
- R2: One cycle after `rx_count` is non-zero and `head_err` has any bit set, the line-status condition is pending in both modes.
- R3: A one-cycle `lsr_rd` clears the line-status condition at the next edge. It stays clear for the same character until a `data_rd` re-arms it; if the error is still present, it is pending again one cycle after that read.
- R4: In FIFO mode, data-available is 1 exactly while `rx_count` >= `trig_level`, following the count up and down in the same cycle. A `trig_level` of 0 acts as 1.
- R5: In non-FIFO mode, data-available is 1 exactly while `rx_count` is non-zero.
- R6: In FIFO mode with a non-empty FIFO, the timeout becomes pending at the edge of the fifth `char_tick` (TO_CHARS+1) counted from when counting began or was last restarted, and not at the fourth.
- R7: While the timeout is not pending, `rx_push` or `data_rd` restarts the count. A push in the same cycle as a tick wins over the tick.
- R8: While the timeout is pending, `rx_push` has no effect. A `data_rd` or `fifo_rst` clears it at the next edge.
- R9: The timeout never becomes pending in non-FIFO mode or while `rx_count` is 0.
- R10: Each output `ls_irq`, `dav_irq`, `tmo_irq` is its pending condition ANDed with its enable. Clearing an enable hides the condition but keeps it pending.
- R11: `irq` is the OR of the three outputs. `irq_id` is 4'b0110 for line status, else 4'b0100 for data available, else 4'b1100 for timeout, else 4'b0001.
- R12: A change of `fifo_mode` clears the line-status and timeout conditions and the tick counter at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| rx_count | input | CW | Characters currently stored |
| head_err | input | ERR_W | Error flags of the oldest stored character |
| rx_push | input | 1 | Receiver stored a new character |
| data_rd | input | 1 | Host read a received character |
| lsr_rd | input | 1 | Host read the line status register |
| fifo_rst | input | 1 | Request to reset the receive FIFO |
| trig_level | input | CW | FIFO-mode data-available threshold |
| en_ls | input | 1 | Line-status interrupt enable |
| en_dav | input | 1 | Data-available interrupt enable |
| en_tmo | input | 1 | Timeout interrupt enable |
| char_tick | input | 1 | One-cycle pulse per character time |
| ls_irq | output | 1 | Enabled line-status interrupt |
| dav_irq | output | 1 | Enabled data-available interrupt |
| tmo_irq | output | 1 | Enabled character-timeout interrupt |
| irq | output | 1 | Combined interrupt line |
| irq_id | output | 4 | Highest-priority pending source code |

## Verification
A receiver push and a character tick can arrive in the same clock cycle, and the block must treat them differently depending on the timeout state. The bench first runs the counter to four ticks in `TO_RUN` and then presents push and tick together. The restart must win, so no timeout may follow, and exactly five further ticks must then be needed. The same combined stimulus is also applied in `TO_FIRED`, where the interrupt must remain pending.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_LS   = 4'b0110,
        IID_DAV  = 4'b0100,
        IID_TMO  = 4'b1100
    } iid_e;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_PEND,
        LS_HELD
    } ls_state_e;

    typedef enum logic [1:0] {
        TO_OFF,
        TO_RUN,
        TO_FIRED
    } to_state_e;

endpackage

// File: rtl/rxirq_ls_fsm.sv
module rxirq_ls_fsm
    import uart_rx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic err_now,
    input  logic lsr_rd,
    input  logic head_pop,
    output logic pend
);

    ls_state_e state_q;
    ls_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (!flush && err_now && !lsr_rd) begin
                    state_d = LS_PEND;
                end
            end
            LS_PEND: begin
                if (flush) begin
                    state_d = LS_IDLE;
                end else if (lsr_rd) begin
                    state_d = LS_HELD;
                end
            end
            LS_HELD: begin
                if (flush || head_pop) begin
                    state_d = LS_IDLE;
                end
            end
            default: state_d = LS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pend = (state_q == LS_PEND);
    end

endmodule

// File: rtl/rxirq_timeout_fsm.sv
module rxirq_timeout_fsm
    import uart_rx_irq_pkg::*;
#(
    parameter int FIRE_AT = 5,
    localparam int CNT_W = $clog2(FIRE_AT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic flush,
    input  logic nonempty,
    input  logic push,
    input  logic rd,
    input  logic tick,
    output logic pend
);

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FIRE_AT - 1);
    localparam logic [CNT_W-1:0] SAT_VAL   = CNT_W'(FIRE_AT);

    to_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TO_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!active || flush || !nonempty) begin
            state_d = TO_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TO_OFF: begin
                    state_d = TO_RUN;
                    cnt_d   = '0;
                end
                TO_RUN: begin
                    if (push || rd) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == LAST_STEP) begin
                            state_d = TO_FIRED;
                            cnt_d   = SAT_VAL;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TO_FIRED: begin
                    if (rd) begin
                        state_d = TO_RUN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = TO_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pend = (state_q == TO_FIRED);
    end

endmodule

// File: rtl/rxirq_prio.sv
module rxirq_prio
    import uart_rx_irq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          fifo_mode,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] trig_level,
    input  logic          ls_pend,
    input  logic          to_pend,
    input  logic          en_ls,
    input  logic          en_dav,
    input  logic          en_tmo,
    output logic          ls_irq,
    output logic          dav_irq,
    output logic          tmo_irq,
    output logic          irq,
    output logic [3:0]    irq_id
);

    logic [CW-1:0] trig_eff;
    logic          dav_pend;
    iid_e          id_sel;

    always_comb begin
        trig_eff = (trig_level == '0) ? CW'(1) : trig_level;
        if (fifo_mode) begin
            dav_pend = (rx_count >= trig_eff);
        end else begin
            dav_pend = (rx_count != '0);
        end
    end

    always_comb begin
        ls_irq  = ls_pend  & en_ls;
        dav_irq = dav_pend & en_dav;
        tmo_irq = to_pend  & en_tmo;
        irq     = ls_irq | dav_irq | tmo_irq;
    end

    always_comb begin
        if (ls_irq) begin
            id_sel = IID_LS;
        end else if (dav_irq) begin
            id_sel = IID_DAV;
        end else if (tmo_irq) begin
            id_sel = IID_TMO;
        end else begin
            id_sel = IID_NONE;
        end
        irq_id = id_sel;
    end

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
    import uart_rx_irq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ERR_W    = 3,
    parameter int TO_CHARS = 4,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [CW-1:0]    rx_count,
    input  logic [ERR_W-1:0] head_err,
    input  logic             rx_push,
    input  logic             data_rd,
    input  logic             lsr_rd,
    input  logic             fifo_rst,
    input  logic [CW-1:0]    trig_level,
    input  logic             en_ls,
    input  logic             en_dav,
    input  logic             en_tmo,
    input  logic             char_tick,
    output logic             ls_irq,
    output logic             dav_irq,
    output logic             tmo_irq,
    output logic             irq,
    output logic [3:0]       irq_id
);

    localparam int FIRE_AT = TO_CHARS + 1;

    logic mode_q;
    logic mode_chg;
    logic ls_flush;
    logic err_now;
    logic nonempty;
    logic to_active;
    logic ls_pend;
    logic to_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_mode;
        end
    end

    always_comb begin
        mode_chg  = (fifo_mode != mode_q);
        ls_flush  = fifo_rst | mode_chg;
        nonempty  = (rx_count != '0);
        err_now   = nonempty & (|head_err);
        to_active = fifo_mode & ~mode_chg;
    end

    rxirq_ls_fsm u_ls (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ls_flush),
        .err_now  (err_now),
        .lsr_rd   (lsr_rd),
        .head_pop (data_rd),
        .pend     (ls_pend)
    );

    rxirq_timeout_fsm #(
        .FIRE_AT (FIRE_AT)
    ) u_to (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (to_active),
        .flush    (fifo_rst),
        .nonempty (nonempty),
        .push     (rx_push),
        .rd       (data_rd),
        .tick     (char_tick),
        .pend     (to_pend)
    );

    rxirq_prio #(
        .CW (CW)
    ) u_prio (
        .fifo_mode  (fifo_mode),
        .rx_count   (rx_count),
        .trig_level (trig_level),
        .ls_pend    (ls_pend),
        .to_pend    (to_pend),
        .en_ls      (en_ls),
        .en_dav     (en_dav),
        .en_tmo     (en_tmo),
        .ls_irq     (ls_irq),
        .dav_irq    (dav_irq),
        .tmo_irq    (tmo_irq),
        .irq        (irq),
        .irq_id     (irq_id)
    );

endmodule

// File: rtl/rxirq_chk.sv
module rxirq_chk
    import uart_rx_irq_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_mode,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] trig_level,
    input logic          rx_push,
    input logic          data_rd,
    input logic          lsr_rd,
    input logic          fifo_rst,
    input logic          en_dav,
    input logic          ls_pend,
    input logic          to_pend,
    input logic          ls_irq,
    input logic          dav_irq,
    input logic [3:0]    irq_id
);

    // R3
    lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd |=> !ls_pend);

    // R8
    fired_push_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_pend && rx_push && !data_rd && !fifo_rst && fifo_mode
         && $past(fifo_mode) && rx_count != '0) |=> to_pend);

    // R8
    fired_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_pend && data_rd) |=> !to_pend);

    // R8
    fifo_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> !to_pend);

    // R9
    nonfifo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !to_pend);

    // R11
    ls_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_irq |-> irq_id == IID_LS);

    // R4
    dav_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && en_dav && trig_level != '0 && rx_count >= trig_level) |-> dav_irq);

endmodule

bind uart_rx_irq rxirq_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .rx_count   (rx_count),
    .trig_level (trig_level),
    .rx_push    (rx_push),
    .data_rd    (data_rd),
    .lsr_rd     (lsr_rd),
    .fifo_rst   (fifo_rst),
    .en_dav     (en_dav),
    .ls_pend    (ls_pend),
    .to_pend    (to_pend),
    .ls_irq     (ls_irq),
    .dav_irq    (dav_irq),
    .irq_id     (irq_id)
);

// File: tb/test_uart_rx_irq.sv
module test_uart_rx_irq;

    localparam int CW = 5;
    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_LS   = 4'b0110;
    localparam logic [3:0] ID_DAV  = 4'b0100;
    localparam logic [3:0] ID_TMO  = 4'b1100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_mode = 1'b1;
    logic [CW-1:0] rx_count = '0;
    logic [2:0]    head_err = '0;
    logic          rx_push = 1'b0;
    logic          data_rd = 1'b0;
    logic          lsr_rd = 1'b0;
    logic          fifo_rst = 1'b0;
    logic [CW-1:0] trig_level = CW'(8);
    logic          en_ls = 1'b1;
    logic          en_dav = 1'b1;
    logic          en_tmo = 1'b1;
    logic          char_tick = 1'b0;
    logic          ls_irq, dav_irq, tmo_irq, irq;
    logic [3:0]    irq_id;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_rx_irq i_uart_rx_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .rx_count   (rx_count),
        .head_err   (head_err),
        .rx_push    (rx_push),
        .data_rd    (data_rd),
        .lsr_rd     (lsr_rd),
        .fifo_rst   (fifo_rst),
        .trig_level (trig_level),
        .en_ls      (en_ls),
        .en_dav     (en_dav),
        .en_tmo     (en_tmo),
        .char_tick  (char_tick),
        .ls_irq     (ls_irq),
        .dav_irq    (dav_irq),
        .tmo_irq    (tmo_irq),
        .irq        (irq),
        .irq_id     (irq_id)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input logic p, input logic r, input logic l,
                       input logic f, input logic t);
        rx_push = p; data_rd = r; lsr_rd = l; fifo_rst = f; char_tick = t;
        step();
        rx_push = 0; data_rd = 0; lsr_rd = 0; fifo_rst = 0; char_tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
    endtask

    task automatic chk(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic chk_id(input logic [3:0] exp, input string what);
        total++;
        if (irq_id !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", what, irq_id, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst_n = 1;
        step();
        step();
        chk(ls_irq, 0, "R1 ls after reset");
        chk(dav_irq, 0, "R1 dav after reset");
        chk(tmo_irq, 0, "R1 tmo after reset");
        chk(irq, 0, "R1 irq after reset");
        chk_id(ID_NONE, "R1 id after reset");
    endtask

    task automatic t_dav_fifo();
        trig_level = 4; rx_count = 3; step();
        chk(dav_irq, 0, "R4 below trigger");
        rx_count = 4; #1;
        chk(dav_irq, 1, "R4 at trigger");
        rx_count = 9; step();
        chk(dav_irq, 1, "R4 above trigger");
        rx_count = 3; #1;
        chk(dav_irq, 0, "R4 falls below trigger");
        trig_level = 0; rx_count = 1; #1;
        chk(dav_irq, 1, "R4 zero trigger acts as one");
        rx_count = 0; trig_level = 8; step();
    endtask

    task automatic t_nonfifo();
        fifo_mode = 0; step(); step();
        rx_count = 1; #1;
        chk(dav_irq, 1, "R5 buffer full");
        rx_count = 0; #1;
        chk(dav_irq, 0, "R5 buffer empty");
        rx_count = 1; head_err = 3'b010; step();
        chk(ls_irq, 1, "R2 non-FIFO error");
        cyc(0, 0, 1, 0, 0);
        chk(ls_irq, 0, "R3 status read clears");
        step(); step();
        chk(ls_irq, 0, "R3 stays clear same char");
        ticks(6);
        chk(tmo_irq, 0, "R9 no timeout in non-FIFO");
        cyc(0, 1, 0, 0, 0);
        chk(ls_irq, 0, "R3 rearm cycle");
        step();
        chk(ls_irq, 1, "R3 rearmed by data read");
        head_err = 0; rx_count = 0;
        cyc(0, 0, 0, 1, 0);
        chk(ls_irq, 0, "R3 cleared by flush");
    endtask

    task automatic t_ls_fifo();
        fifo_mode = 1; step(); step();
        rx_count = 5; head_err = 3'b001; step();
        chk(ls_irq, 1, "R2 FIFO head error");
        chk_id(ID_LS, "R11 line status only");
        trig_level = 2; #1;
        chk_id(ID_LS, "R11 line status over data");
        chk(irq, 1, "R11 irq line");
        cyc(0, 0, 1, 0, 0);
        chk_id(ID_DAV, "R11 data after status read");
        head_err = 0; rx_count = 0; trig_level = 8;
        cyc(0, 0, 0, 1, 0);
        chk(irq, 0, "R11 irq idle");
    endtask

    task automatic t_timeout();
        rx_count = 2;
        cyc(1, 0, 0, 0, 0);
        ticks(4);
        chk(tmo_irq, 0, "R6 not after four ticks");
        ticks(1);
        chk(tmo_irq, 1, "R6 fires on fifth tick");
        chk_id(ID_TMO, "R11 timeout id");
        cyc(1, 0, 0, 0, 0);
        chk(tmo_irq, 1, "R8 push ignored when fired");
        cyc(1, 0, 0, 0, 1);
        chk(tmo_irq, 1, "R8 push+tick ignored when fired");
        cyc(0, 1, 0, 0, 0);
        chk(tmo_irq, 0, "R8 data read clears");
        ticks(4);
        cyc(1, 0, 0, 0, 1);
        chk(tmo_irq, 0, "R7 push beats tick");
        ticks(4);
        chk(tmo_irq, 0, "R7 push restarted count");
        ticks(1);
        chk(tmo_irq, 1, "R7 fires five ticks after push");
        en_tmo = 0; #1;
        chk(tmo_irq, 0, "R10 enable hides timeout");
        chk_id(ID_NONE, "R10 id with source disabled");
        en_tmo = 1; #1;
        chk(tmo_irq, 1, "R10 pending kept under disable");
        cyc(0, 0, 0, 1, 0);
        chk(tmo_irq, 0, "R8 FIFO reset clears");
        step();
        ticks(3);
        cyc(0, 1, 0, 0, 0);
        ticks(4);
        chk(tmo_irq, 0, "R7 data read restarted count");
        ticks(1);
        chk(tmo_irq, 1, "R6 fires again");
        fifo_mode = 0; step();
        chk(tmo_irq, 0, "R12 mode change clears");
        fifo_mode = 1; step();
        ticks(4);
        chk(tmo_irq, 0, "R12 counter cleared by mode change");
        rx_count = 0; step();
        ticks(7);
        chk(tmo_irq, 0, "R9 no timeout when empty");
    endtask

    initial begin
        t_reset();
        t_dav_fifo();
        t_nonfifo();
        t_ls_fifo();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule